// File: doc/BRIEF.md
# Virtualized Measurement Register Bank

This block keeps the measurement registers of a trusted platform for one host and several virtual machines. Each register holds a 256-bit value and the identifier of the hash algorithm that last changed it. The first eight indices form one bank that describes the platform. Every machine sees this same bank and may read it, but only the host may change it. The next sixteen indices are copied once per machine, so each machine has a private set that no other machine can see or change.

A register never takes a written value. It changes only through an extend request. The request names a context (host or machine), a machine id, an index, an algorithm identifier and a digest. The block joins the old value, the identifier and the digest into one operand and gives it to an outside hash engine through a request/done handshake. It stores the result that comes back, together with the identifier. Only one extend can be in progress at a time. The separate read port keeps working while an extend waits for the engine, so values can still be fetched for attestation.

Top module: `vpcr_bank`

## Requirements
- R1: After reset every register reads as value zero with algorithm identifier 0x000B, and `ext_ready` is high.
- R2: A read request is answered one cycle later by `rd_resp_valid` with the value and the algorithm identifier. Indices 0 to 7 return the same shared register whichever valid machine id is named.
- R3: An accepted extend raises `hash_req` in the next cycle and holds it, with `hash_msg` stable, until `hash_done`. The layout of `hash_msg` is {old value [527:272], algorithm id [271:256], digest [255:0]}.
- R4: In the cycle in which `hash_done` is seen, the target register takes `hash_result` and the request's algorithm identifier. In the next cycle `resp_valid` pulses with `resp_err` = 0.
- R5: A machine-context extend (`ext_host`=0) to index 0 to 7 is rejected with `resp_err` = 1 and changes no register.
- R6: An index above 23 is rejected with error code 2, for both extends and reads. This check comes before every other check.
- R7: A machine id of 4 or more is rejected with error code 3 and changes nothing. A rejected read returns value zero.
- R8: A host-context extend to index 0 to 7 updates the shared bank and ignores the machine id. A host extend to index 8 to 23 targets the named machine's private register.
- R9: An extend to a private index changes only the named machine's copy. The same index of every other machine keeps its value.
- R10: While an extend waits for the hash engine, `ext_ready` is low, and reads are still answered with one-cycle latency.
- R11: A rejected extend gives `resp_valid` with its code one cycle after acceptance. It raises no `hash_req`, and `ext_ready` stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ext_valid | input | 1 | Extend request valid |
| ext_ready | output | 1 | High when an extend can be accepted |
| ext_host | input | 1 | 1 = host context, 0 = machine context |
| ext_vm | input | 3 | Target machine id |
| ext_idx | input | 5 | Target register index |
| ext_alg | input | 16 | Hash algorithm identifier |
| ext_digest | input | 256 | Measured digest |
| resp_valid | output | 1 | Extend completion or rejection pulse |
| resp_err | output | 2 | 0 ok, 1 shared bank read-only, 2 index range, 3 unknown machine |
| hash_req | output | 1 | Operand valid toward the hash engine |
| hash_msg | output | 528 | Operand {old, alg, digest} |
| hash_done | input | 1 | Hash engine result valid |
| hash_result | input | 256 | New register value |
| rd_valid | input | 1 | Read request |
| rd_vm | input | 3 | Reading machine id |
| rd_idx | input | 5 | Register index to read |
| rd_resp_valid | output | 1 | Read answer valid |
| rd_value | output | 256 | Register value |
| rd_alg | output | 16 | Stored algorithm identifier |
| rd_err | output | 2 | Read error code, same coding as resp_err |

## Verification
The hardest situation to reach is a read that arrives while an extend is stalled on the hash engine. The bench controls the engine's `hash_done` itself, so it holds the engine busy for several cycles. During that window it issues reads, checks that each one answers on time, and checks that `ext_ready` stays low. Isolation between machines is checked by extending one machine's private register and then reading the same index through every other machine id. Error priority is checked with requests that break two rules at once.

// File: rtl/vpcr_pkg.sv
// Shared types for the virtualized measurement register bank.
package vpcr_pkg;
    // Extend and read status codes, also driven on resp_err / rd_err.
    typedef enum logic [1:0] {
        ERR_NONE      = 2'd0,
        ERR_SHARED_RO = 2'd1,
        ERR_RANGE     = 2'd2,
        ERR_BAD_VM    = 2'd3
    } vpcr_err_e;
endpackage

// File: rtl/vpcr_decode.sv
// Address decoder: maps (context, machine id, index) onto a flat storage slot
// and reports the rejection code. Index range is checked first. Then a
// machine-context write to the shared bank is refused. Then an unknown machine
// id is refused (a host write to the shared bank ignores the id).
// Assumes the slot layout: shared bank first, then PRIV_N slots per machine.
module vpcr_decode
    import vpcr_pkg::*;
#(
    parameter int NUM_VM   = 4,
    parameter int SHARED_N = 8,
    parameter int PRIV_N   = 16,
    parameter int VMID_W   = 3,
    parameter int IDX_W    = 5,
    parameter int SLOT_W   = 7
) (
    input  logic              is_write,
    input  logic              host,
    input  logic [VMID_W-1:0] vm,
    input  logic [IDX_W-1:0]  idx,
    output vpcr_err_e         err,
    output logic [SLOT_W-1:0] slot
);
    localparam int TOTAL_IDX = SHARED_N + PRIV_N;

    // Purpose: classify the request and compute its storage slot.
    always_comb begin
        err  = ERR_NONE;
        slot = '0;
        if (int'(idx) >= TOTAL_IDX) begin
            err = ERR_RANGE;
        end else if (int'(idx) < SHARED_N) begin
            if (is_write && !host) begin
                err = ERR_SHARED_RO;
            end else if (!is_write && int'(vm) >= NUM_VM) begin
                err = ERR_BAD_VM;
            end else begin
                slot = SLOT_W'(idx);
            end
        end else if (int'(vm) >= NUM_VM) begin
            err = ERR_BAD_VM;
        end else begin
            slot = SLOT_W'(SHARED_N + int'(vm) * PRIV_N + int'(idx) - SHARED_N);
        end
    end
endmodule

// File: rtl/vpcr_store.sv
// Register storage: TOTAL slots of value plus algorithm id, one write port and
// two combinational read ports. Assumes slot numbers come from vpcr_decode.
module vpcr_store #(
    parameter int          TOTAL   = 72,
    parameter int          VAL_W   = 256,
    parameter int          ALG_W   = 16,
    parameter int          SLOT_W  = 7,
    parameter logic [15:0] DEF_ALG = 16'h000B
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [SLOT_W-1:0] wr_slot,
    input  logic [VAL_W-1:0]  wr_val,
    input  logic [ALG_W-1:0]  wr_alg,
    input  logic [SLOT_W-1:0] a_slot,
    output logic [VAL_W-1:0]  a_val,
    output logic [ALG_W-1:0]  a_alg,
    input  logic [SLOT_W-1:0] b_slot,
    output logic [VAL_W-1:0]  b_val
);
    logic [VAL_W-1:0] val_q [TOTAL];
    logic [ALG_W-1:0] alg_q [TOTAL];

    for (genvar s = 0; s < TOTAL; s++) begin : g_slot
        // Purpose: hold one register; clear on reset, load on a matching write.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                val_q[s] <= '0;
                alg_q[s] <= ALG_W'(DEF_ALG);
            end else if (wr_en && wr_slot == SLOT_W'(s)) begin
                val_q[s] <= wr_val;
                alg_q[s] <= wr_alg;
            end
        end
    end

    assign a_val = (int'(a_slot) < TOTAL) ? val_q[a_slot] : '0;
    assign a_alg = (int'(a_slot) < TOTAL) ? alg_q[a_slot] : '0;
    assign b_val = (int'(b_slot) < TOTAL) ? val_q[b_slot] : '0;

    AST_WRITE_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> int'(wr_slot) < TOTAL) else $error("write slot out of range"); // R9
endmodule

// File: rtl/vpcr_ctrl.sv
// Extend sequencer. It accepts one request while idle. A rejected request is
// answered at once. An accepted request latches {old, alg, digest}, holds
// hash_req until hash_done, then writes the result and answers.
// Assumes chk_err/chk_slot/old_val are combinational functions of the request.
module vpcr_ctrl
    import vpcr_pkg::*;
#(
    parameter int VAL_W  = 256,
    parameter int ALG_W  = 16,
    parameter int SLOT_W = 7,
    localparam int MSG_W = 2 * VAL_W + ALG_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ext_valid,
    output logic              ext_ready,
    input  logic [ALG_W-1:0]  ext_alg,
    input  logic [VAL_W-1:0]  ext_digest,
    input  vpcr_err_e         chk_err,
    input  logic [SLOT_W-1:0] chk_slot,
    input  logic [VAL_W-1:0]  old_val,
    output logic              hash_req,
    output logic [MSG_W-1:0]  hash_msg,
    input  logic              hash_done,
    input  logic [VAL_W-1:0]  hash_result,
    output logic              wr_en,
    output logic [SLOT_W-1:0] wr_slot,
    output logic [VAL_W-1:0]  wr_val,
    output logic [ALG_W-1:0]  wr_alg,
    output logic              resp_valid,
    output vpcr_err_e         resp_err
);
    typedef enum logic {ST_IDLE, ST_HASH} st_e;

    st_e               st_q;
    logic [SLOT_W-1:0] slot_q;
    logic [ALG_W-1:0]  alg_q;
    logic [MSG_W-1:0]  msg_q;

    // Purpose: sequence accept, hash wait and response.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q       <= ST_IDLE;
            slot_q     <= '0;
            alg_q      <= '0;
            msg_q      <= '0;
            resp_valid <= 1'b0;
            resp_err   <= ERR_NONE;
        end else begin
            resp_valid <= 1'b0;
            case (st_q)
                ST_IDLE: if (ext_valid) begin
                    if (chk_err != ERR_NONE) begin
                        resp_valid <= 1'b1;
                        resp_err   <= chk_err;
                    end else begin
                        st_q   <= ST_HASH;
                        slot_q <= chk_slot;
                        alg_q  <= ext_alg;
                        msg_q  <= {old_val, ext_alg, ext_digest};
                    end
                end
                ST_HASH: if (hash_done) begin
                    st_q       <= ST_IDLE;
                    resp_valid <= 1'b1;
                    resp_err   <= ERR_NONE;
                end
                default: st_q <= ST_IDLE;
            endcase
        end
    end

    assign ext_ready = (st_q == ST_IDLE);
    assign hash_req  = (st_q == ST_HASH);
    assign hash_msg  = msg_q;
    assign wr_en     = hash_req && hash_done;
    assign wr_slot   = slot_q;
    assign wr_val    = hash_result;
    assign wr_alg    = alg_q;

    AST_HASH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        hash_req && !hash_done |=> hash_req && $stable(hash_msg)) else $error("hash request dropped"); // R3
    AST_DONE_RESPONDS: assert property (@(posedge clk) disable iff (!rst_n)
        hash_req && hash_done |=> resp_valid && resp_err == ERR_NONE) else $error("no completion"); // R4
endmodule

// File: rtl/vpcr_bank.sv
// Top of the virtualized measurement register bank: shared platform bank plus
// per-machine private registers, extend through an external hash port, and a
// one-cycle-latency read port that stays live during an extend.
module vpcr_bank
    import vpcr_pkg::*;
#(
    parameter int          NUM_VM   = 4,
    parameter int          SHARED_N = 8,
    parameter int          PRIV_N   = 16,
    parameter int          VAL_W    = 256,
    parameter int          ALG_W    = 16,
    parameter int          VMID_W   = 3,
    parameter int          IDX_W    = 5,
    parameter logic [15:0] DEF_ALG  = 16'h000B,
    localparam int         MSG_W    = 2 * VAL_W + ALG_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ext_valid,
    output logic              ext_ready,
    input  logic              ext_host,
    input  logic [VMID_W-1:0] ext_vm,
    input  logic [IDX_W-1:0]  ext_idx,
    input  logic [ALG_W-1:0]  ext_alg,
    input  logic [VAL_W-1:0]  ext_digest,
    output logic              resp_valid,
    output logic [1:0]        resp_err,
    output logic              hash_req,
    output logic [MSG_W-1:0]  hash_msg,
    input  logic              hash_done,
    input  logic [VAL_W-1:0]  hash_result,
    input  logic              rd_valid,
    input  logic [VMID_W-1:0] rd_vm,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic              rd_resp_valid,
    output logic [VAL_W-1:0]  rd_value,
    output logic [ALG_W-1:0]  rd_alg,
    output logic [1:0]        rd_err
);
    localparam int TOTAL  = SHARED_N + NUM_VM * PRIV_N;
    localparam int SLOT_W = $clog2(TOTAL);

    vpcr_err_e         x_err, r_err, c_resp_err;
    logic [SLOT_W-1:0] x_slot, r_slot, w_slot;
    logic [VAL_W-1:0]  old_val, a_val, w_val;
    logic [ALG_W-1:0]  a_alg, w_alg;
    logic              w_en;

    vpcr_decode #(.NUM_VM(NUM_VM), .SHARED_N(SHARED_N), .PRIV_N(PRIV_N),
                  .VMID_W(VMID_W), .IDX_W(IDX_W), .SLOT_W(SLOT_W)) u_ext_dec (
        .is_write(1'b1), .host(ext_host), .vm(ext_vm), .idx(ext_idx),
        .err(x_err), .slot(x_slot));

    vpcr_decode #(.NUM_VM(NUM_VM), .SHARED_N(SHARED_N), .PRIV_N(PRIV_N),
                  .VMID_W(VMID_W), .IDX_W(IDX_W), .SLOT_W(SLOT_W)) u_rd_dec (
        .is_write(1'b0), .host(1'b0), .vm(rd_vm), .idx(rd_idx),
        .err(r_err), .slot(r_slot));

    vpcr_store #(.TOTAL(TOTAL), .VAL_W(VAL_W), .ALG_W(ALG_W), .SLOT_W(SLOT_W),
                 .DEF_ALG(DEF_ALG)) u_store (
        .clk(clk), .rst_n(rst_n), .wr_en(w_en), .wr_slot(w_slot), .wr_val(w_val),
        .wr_alg(w_alg), .a_slot(r_slot), .a_val(a_val), .a_alg(a_alg),
        .b_slot(x_slot), .b_val(old_val));

    vpcr_ctrl #(.VAL_W(VAL_W), .ALG_W(ALG_W), .SLOT_W(SLOT_W)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .ext_valid(ext_valid), .ext_ready(ext_ready),
        .ext_alg(ext_alg), .ext_digest(ext_digest), .chk_err(x_err),
        .chk_slot(x_slot), .old_val(old_val), .hash_req(hash_req),
        .hash_msg(hash_msg), .hash_done(hash_done), .hash_result(hash_result),
        .wr_en(w_en), .wr_slot(w_slot), .wr_val(w_val), .wr_alg(w_alg),
        .resp_valid(resp_valid), .resp_err(c_resp_err));

    assign resp_err = c_resp_err;

    // Purpose: register the read answer; rejected reads return zero data.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_resp_valid <= 1'b0;
            rd_value      <= '0;
            rd_alg        <= '0;
            rd_err        <= 2'd0;
        end else begin
            rd_resp_valid <= rd_valid;
            if (rd_valid) begin
                rd_err   <= r_err;
                rd_value <= (r_err == ERR_NONE) ? a_val : '0;
                rd_alg   <= (r_err == ERR_NONE) ? a_alg : '0;
            end
        end
    end

    AST_REJECT_NO_HASH: assert property (@(posedge clk) disable iff (!rst_n)
        ext_valid && ext_ready && x_err != ERR_NONE |=> !hash_req && resp_valid && ext_ready) else $error("reject path"); // R11
    AST_READ_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |=> rd_resp_valid) else $error("read latency"); // R2
    AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
        hash_req |-> !ext_ready) else $error("ready while busy"); // R10
endmodule

// File: tb/vpcr_bank_tb_top.sv
// Directed bench: bench-side model of every register, hash engine driven here.
module vpcr_bank_tb_top;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2.5 clk = ~clk;

    logic ext_valid = 0, ext_host = 0, hash_done = 0, rd_valid = 0;
    logic [2:0] ext_vm = 0, rd_vm = 0;
    logic [4:0] ext_idx = 0, rd_idx = 0;
    logic [15:0] ext_alg = 0;
    logic [255:0] ext_digest = 0, hash_result = 0;
    logic ext_ready, resp_valid, hash_req, rd_resp_valid;
    logic [1:0] resp_err, rd_err;
    logic [527:0] hash_msg;
    logic [255:0] rd_value;
    logic [15:0] rd_alg;

    vpcr_bank dut_i (
        .clk(clk), .rst_n(rst_n), .ext_valid(ext_valid), .ext_ready(ext_ready),
        .ext_host(ext_host), .ext_vm(ext_vm), .ext_idx(ext_idx), .ext_alg(ext_alg),
        .ext_digest(ext_digest), .resp_valid(resp_valid), .resp_err(resp_err),
        .hash_req(hash_req), .hash_msg(hash_msg), .hash_done(hash_done),
        .hash_result(hash_result), .rd_valid(rd_valid), .rd_vm(rd_vm),
        .rd_idx(rd_idx), .rd_resp_valid(rd_resp_valid), .rd_value(rd_value),
        .rd_alg(rd_alg), .rd_err(rd_err));

    int checks = 0, errors = 0;
    logic [255:0] sh_v [8];
    logic [15:0]  sh_a [8];
    logic [255:0] pv_v [4][16];
    logic [15:0]  pv_a [4][16];

    task automatic chk(input bit ok, input string tag, input logic [527:0] act, input logic [527:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [255:0] mdl_val(input int vm, input int idx);
        return (idx < 8) ? sh_v[idx] : pv_v[vm][idx-8];
    endfunction
    function automatic logic [15:0] mdl_alg(input int vm, input int idx);
        return (idx < 8) ? sh_a[idx] : pv_a[vm][idx-8];
    endfunction
    // Bench hash engine transfer function.
    function automatic logic [255:0] hfun(input logic [255:0] old, input logic [15:0] alg, input logic [255:0] dig);
        return old ^ {dig[254:0], dig[255]} ^ {240'd0, alg} ^ 256'h1;
    endfunction

    task automatic do_read(input int vm, input int idx, input logic [255:0] ev,
                           input logic [15:0] ea, input logic [1:0] ee, input string tag);
        rd_valid = 1; rd_vm = 3'(vm); rd_idx = 5'(idx);
        @(negedge clk);
        rd_valid = 0;
        chk(rd_resp_valid === 1'b1, {tag, " rd_resp_valid"}, rd_resp_valid, 1);
        chk(rd_err === ee, {tag, " rd_err"}, rd_err, ee);
        chk(rd_value === ev, {tag, " rd_value"}, rd_value, ev);
        chk(rd_alg === ea, {tag, " rd_alg"}, rd_alg, ea);
    endtask

    task automatic do_extend(input bit host, input int vm, input int idx, input logic [15:0] alg,
                             input logic [255:0] dig, input int delay, input logic [1:0] ee, input string tag);
        logic [255:0] old, nv;
        while (ext_ready !== 1'b1) @(negedge clk);
        ext_valid = 1; ext_host = host; ext_vm = 3'(vm); ext_idx = 5'(idx);
        ext_alg = alg; ext_digest = dig;
        @(negedge clk);
        ext_valid = 0;
        if (ee != 2'd0) begin
            chk(resp_valid === 1'b1 && resp_err === ee, {tag, " reject code"}, {resp_valid, resp_err}, {1'b1, ee});
            chk(hash_req === 1'b0 && ext_ready === 1'b1, {tag, " reject no hash"}, {hash_req, ext_ready}, 2'b01);
        end else begin
            old = mdl_val(vm, idx);
            chk(hash_req === 1'b1, {tag, " hash_req"}, hash_req, 1);
            chk(hash_msg === {old, alg, dig}, {tag, " hash_msg"}, hash_msg, {old, alg, dig});
            for (int i = 0; i < delay; i++) begin
                chk(ext_ready === 1'b0 && hash_req === 1'b1, {tag, " busy hold"}, {ext_ready, hash_req}, 2'b01);
                @(negedge clk);
            end
            nv = hfun(hash_msg[527:272], hash_msg[271:256], hash_msg[255:0]);
            hash_done = 1; hash_result = nv;
            @(negedge clk);
            hash_done = 0;
            chk(resp_valid === 1'b1 && resp_err === 2'd0, {tag, " completion"}, {resp_valid, resp_err}, 3'b100);
            nv = hfun(old, alg, dig);
            if (idx < 8) begin sh_v[idx] = nv; sh_a[idx] = alg; end
            else begin pv_v[vm][idx-8] = nv; pv_a[vm][idx-8] = alg; end
        end
    endtask

    task automatic t_reset();
        chk(ext_ready === 1'b1, "R1 ready after reset", ext_ready, 1);
        do_read(0, 0, '0, 16'h000B, 0, "R1 vm0 idx0");
        do_read(3, 23, '0, 16'h000B, 0, "R1 vm3 idx23");
    endtask

    task automatic t_host_shared();
        do_extend(1, 6, 3, 16'h0012, {8{32'hA5A5_0001}}, 2, 0, "R8 host idx3");
        for (int v = 0; v < 4; v++) do_read(v, 3, mdl_val(v, 3), mdl_alg(v, 3), 0, "R2 R8 shared view");
        do_extend(1, 0, 7, 16'h000B, 256'hBEEF, 0, 0, "R4 host idx7");
        do_read(2, 7, mdl_val(2, 7), mdl_alg(2, 7), 0, "R4 idx7 readback");
    endtask

    task automatic t_private();
        do_extend(0, 1, 10, 16'h000C, 256'h1234_5678, 1, 0, "R4 vm1 idx10");
        do_extend(0, 1, 10, 16'h000D, 256'hCAFE, 1, 0, "R3 chained old value");
        do_read(1, 10, mdl_val(1, 10), mdl_alg(1, 10), 0, "R4 vm1 idx10 read");
        for (int v = 0; v < 4; v++)
            if (v != 1) do_read(v, 10, '0, 16'h000B, 0, "R9 other vm untouched");
        do_extend(1, 3, 23, 16'h0027, 256'h77, 0, 0, "R8 host private vm3 idx23");
        do_extend(0, 3, 8, 16'h0001, 256'h88, 3, 0, "R4 vm3 idx8");
        do_read(3, 23, mdl_val(3, 23), mdl_alg(3, 23), 0, "R8 vm3 idx23 read");
        do_read(2, 23, '0, 16'h000B, 0, "R9 vm2 idx23 untouched");
    endtask

    task automatic t_reject();
        do_extend(0, 0, 5, 16'h0003, 256'h99, 0, 1, "R5 vm to shared");
        do_read(0, 5, mdl_val(0, 5), mdl_alg(0, 5), 0, "R5 shared unchanged");
        do_extend(0, 2, 24, 16'h0003, 256'h99, 0, 2, "R6 index 24");
        do_extend(0, 7, 31, 16'h0003, 256'h99, 0, 2, "R6 range before vm");
        do_extend(0, 5, 12, 16'h0003, 256'h99, 0, 3, "R7 unknown vm");
        do_read(0, 12, '0, 16'h000B, 0, "R7 no change vm0 idx12");
        do_read(4, 0, '0, '0, 3, "R7 read unknown vm");
        do_read(1, 30, '0, '0, 2, "R6 read out of range");
        chk(ext_ready === 1'b1, "R11 ready after rejects", ext_ready, 1);
    endtask

    task automatic t_busy_read();
        logic [255:0] old;
        while (ext_ready !== 1'b1) @(negedge clk);
        old = mdl_val(2, 15);
        ext_valid = 1; ext_host = 0; ext_vm = 3'd2; ext_idx = 5'd15; ext_alg = 16'h0044; ext_digest = 256'h5555;
        @(negedge clk);
        ext_valid = 0;
        chk(hash_req === 1'b1, "R10 busy started", hash_req, 1);
        do_read(1, 10, mdl_val(1, 10), mdl_alg(1, 10), 0, "R10 read during extend");
        do_read(0, 3, mdl_val(0, 3), mdl_alg(0, 3), 0, "R10 shared read during extend");
        chk(ext_ready === 1'b0, "R10 ready low while busy", ext_ready, 0);
        hash_done = 1; hash_result = hfun(hash_msg[527:272], hash_msg[271:256], hash_msg[255:0]);
        @(negedge clk);
        hash_done = 0;
        chk(resp_valid === 1'b1 && ext_ready === 1'b1, "R10 completes", {resp_valid, ext_ready}, 2'b11);
        pv_v[2][7] = hfun(old, 16'h0044, 256'h5555); pv_a[2][7] = 16'h0044;
        do_read(2, 15, mdl_val(2, 15), mdl_alg(2, 15), 0, "R4 vm2 idx15 after busy");
    endtask

    initial begin
        for (int i = 0; i < 8; i++) begin sh_v[i] = '0; sh_a[i] = 16'h000B; end
        for (int v = 0; v < 4; v++)
            for (int i = 0; i < 16; i++) begin pv_v[v][i] = '0; pv_a[v][i] = 16'h000B; end
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        t_reset();
        t_host_shared();
        t_private();
        t_reject();
        t_busy_read();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule